// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the general-purpose register file of a small RISC core whose calling convention uses register windows. The core names 32 logical registers. Eight are global and look the same from every procedure. The other 24 are split into three groups of eight: incoming parameters, locals and outgoing temporaries. A window pointer selects which physical window these 24 names refer to. The physical windows form a ring. A caller's outgoing temporaries are the same storage as the callee's incoming parameters, so arguments and results cross a call without being copied.

A call request moves the current window pointer one step forward and a return request moves it one step back. A second pointer marks the boundary between windows held in the ring and windows spilled to memory. When a call would run into that boundary, the block raises an overflow trap and holds the call. When a return would step past the oldest resident window, the block raises an underflow trap and holds the return. An external handler spills or fills one window and then acknowledges. The acknowledge moves the boundary pointer by one step, and the held request completes once it no longer traps. The core keeps its call or return request asserted until the request is taken.

Top module: `rwf_window_file`

## Requirements
- R1: A logical register number has five bits. Bits [4:3] select the group (0 global, 1 parameter, 2 local, 3 temporary) and bits [2:0] select the register within the group.
- R2: Temporary register i seen from window w is the same storage as parameter register i seen from window (w+1) mod 8. Parameter and local registers of different windows are distinct storage.
- R3: A call request (call high, return low) that does not trap increments the current window pointer modulo 8 at the next clock edge. A return request (return high, call low) that does not trap decrements it modulo 8.
- R4: The global registers are the same storage from every window and keep their contents across calls and returns.
- R5: The overflow output is high in the same cycle as a call request when (current pointer + 2) mod 8 equals the saved pointer. While it is high the current pointer does not change.
- R6: The underflow output is high in the same cycle as a return request when the current pointer equals the saved pointer. While it is high the current pointer does not change.
- R7: A save acknowledge in a cycle with overflow high increments the saved pointer modulo 8. A restore acknowledge in a cycle with underflow high decrements it. An acknowledge in any other cycle is ignored.
- R8: Global register 0 always reads as zero, and writes to it are ignored.
- R9: After reset both pointers are 0 and every register reads as zero.
- R10: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is visible from the next cycle.
- R11: When call and return are high together, neither pointer moves and neither trap is raised.
- R12: A write in the same cycle as a call or return is placed through the window pointer that was in effect before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call request, held until taken |
| ret_i | input | 1 | Return request, held until taken |
| save_ack_i | input | 1 | Handler finished spilling one window |
| restore_ack_i | input | 1 | Handler finished filling one window |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical register to write |
| wr_data_i | input | 32 | Write data |
| rd_a_addr_i | input | 5 | Logical register for read port A |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 5 | Logical register for read port B |
| rd_b_data_o | output | 32 | Read port B data |
| ovf_trap_o | output | 1 | Window overflow trap |
| unf_trap_o | output | 1 | Window underflow trap |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer |

## Verification
The bench builds the block with its default parameters: 8 windows, 8 registers per group and 32-bit data. With only 8 windows the ring wraps after a handful of calls. Runs of nested calls and returns therefore reach both traps and both pointer wrap-arounds many times. They also reach the case where the last window's temporaries alias window 0's parameters. A behavioural model keyed by (window, group, index) predicts every read, trap and pointer value on each cycle, while random handler delays move the boundary pointer in both directions.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_PARAM  = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_TEMP   = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        WOP_HOLD = 2'd0,
        WOP_CALL = 2'd1,
        WOP_RET  = 2'd2
    } win_op_e;

    // Physical slot of a logical register: globals first, then per window
    // its parameter group followed by its local group. Temporaries of
    // window w land on the parameter group of window w+1.
    function automatic int unsigned slot_of(grp_e g, int unsigned idx,
                                            int unsigned win, int unsigned nwin,
                                            int unsigned grp_sz);
        int unsigned stride;
        stride = 2 * grp_sz;
        case (g)
            GRP_GLOBAL: slot_of = idx;
            GRP_PARAM:  slot_of = grp_sz + win * stride + idx;
            GRP_LOCAL:  slot_of = grp_sz + win * stride + grp_sz + idx;
            default:    slot_of = grp_sz + ((win + 1) % nwin) * stride + idx;
        endcase
    endfunction

endpackage

// File: rtl/rwf_map.sv
module rwf_map
    import rwf_pkg::*;
#(
    parameter int unsigned NWIN   = 8,
    parameter int unsigned GRP_SZ = 8,
    localparam int unsigned GRP_W  = $clog2(GRP_SZ),
    localparam int unsigned LREG_W = GRP_W + 2,
    localparam int unsigned PW     = $clog2(NWIN),
    localparam int unsigned NPHYS  = GRP_SZ + NWIN * 2 * GRP_SZ,
    localparam int unsigned PHYS_W = $clog2(NPHYS)
) (
    input  logic [PW-1:0]     cwp_i,
    input  logic [LREG_W-1:0] laddr_i,
    output logic [PHYS_W-1:0] paddr_o
);

    grp_e grp;
    logic [GRP_W-1:0] idx;

    always_comb begin
        grp     = grp_e'(laddr_i[LREG_W-1 -: 2]);
        idx     = laddr_i[GRP_W-1:0];
        paddr_o = PHYS_W'(slot_of(grp, 32'(idx), 32'(cwp_i), NWIN, GRP_SZ));
    end

endmodule

// File: rtl/rwf_ptr.sv
module rwf_ptr
    import rwf_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    localparam int unsigned PW  = $clog2(NWIN)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          save_ack_i,
    input  logic          restore_ack_i,
    output logic [PW-1:0] cwp_o,
    output logic [PW-1:0] swp_o,
    output logic          ovf_o,
    output logic          unf_o
);

    win_op_e op;
    logic    ring_full;
    logic    ring_empty;
    logic [PW-1:0] cwp_q, swp_q;

    always_comb begin
        if (call_i && !ret_i)      op = WOP_CALL;
        else if (ret_i && !call_i) op = WOP_RET;
        else                       op = WOP_HOLD;
        ring_full  = (PW'(cwp_q + PW'(2)) == swp_q);
        ring_empty = (cwp_q == swp_q);
        ovf_o      = (op == WOP_CALL) && ring_full;
        unf_o      = (op == WOP_RET) && ring_empty;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cwp_q <= '0;
            swp_q <= '0;
        end else begin
            if (op == WOP_CALL && !ring_full)
                cwp_q <= cwp_q + PW'(1);
            else if (op == WOP_RET && !ring_empty)
                cwp_q <= cwp_q - PW'(1);
            if (ovf_o && save_ack_i)
                swp_q <= swp_q + PW'(1);
            else if (unf_o && restore_ack_i)
                swp_q <= swp_q - PW'(1);
        end
    end

    assign cwp_o = cwp_q;
    assign swp_o = swp_q;

endmodule

// File: rtl/rwf_store.sv
module rwf_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NPHYS  = 136,
    localparam int unsigned PHYS_W = $clog2(NPHYS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [PHYS_W-1:0] wa_i,
    input  logic [DATA_W-1:0] wd_i,
    input  logic [PHYS_W-1:0] ra_a_i,
    output logic [DATA_W-1:0] rd_a_o,
    input  logic [PHYS_W-1:0] ra_b_i,
    output logic [DATA_W-1:0] rd_b_o
);

    logic [DATA_W-1:0] cells_q [NPHYS];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int k = 0; k < int'(NPHYS); k++) cells_q[k] <= '0;
        end else if (we_i && wa_i != '0 && 32'(wa_i) < NPHYS) begin
            cells_q[wa_i] <= wd_i;
        end
    end

    always_comb begin
        rd_a_o = (32'(ra_a_i) < NPHYS && ra_a_i != '0) ? cells_q[ra_a_i] : '0;
        rd_b_o = (32'(ra_b_i) < NPHYS && ra_b_i != '0) ? cells_q[ra_b_i] : '0;
    end

endmodule

// File: rtl/rwf_window_file.sv
module rwf_window_file
    import rwf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NWIN   = 8,
    parameter int unsigned GRP_SZ = 8,
    localparam int unsigned GRP_W  = $clog2(GRP_SZ),
    localparam int unsigned LREG_W = GRP_W + 2,
    localparam int unsigned PW     = $clog2(NWIN),
    localparam int unsigned NPHYS  = GRP_SZ + NWIN * 2 * GRP_SZ,
    localparam int unsigned PHYS_W = $clog2(NPHYS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              save_ack_i,
    input  logic              restore_ack_i,
    input  logic              wr_en_i,
    input  logic [LREG_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [LREG_W-1:0] rd_a_addr_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [LREG_W-1:0] rd_b_addr_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    output logic              ovf_trap_o,
    output logic              unf_trap_o,
    output logic [PW-1:0]     cwp_o,
    output logic [PW-1:0]     swp_o
);

    logic [PW-1:0]     cwp;
    logic [PHYS_W-1:0] paddr [3];
    logic [LREG_W-1:0] laddr [3];

    assign laddr[0] = wr_addr_i;
    assign laddr[1] = rd_a_addr_i;
    assign laddr[2] = rd_b_addr_i;

    rwf_ptr #(.NWIN(NWIN)) u_ptr (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .call_i       (call_i),
        .ret_i        (ret_i),
        .save_ack_i   (save_ack_i),
        .restore_ack_i(restore_ack_i),
        .cwp_o        (cwp),
        .swp_o        (swp_o),
        .ovf_o        (ovf_trap_o),
        .unf_o        (unf_trap_o)
    );

    for (genvar p = 0; p < 3; p++) begin : g_map
        rwf_map #(.NWIN(NWIN), .GRP_SZ(GRP_SZ)) u_map (
            .cwp_i  (cwp),
            .laddr_i(laddr[p]),
            .paddr_o(paddr[p])
        );
    end

    rwf_store #(.DATA_W(DATA_W), .NPHYS(NPHYS)) u_store (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .we_i  (wr_en_i),
        .wa_i  (paddr[0]),
        .wd_i  (wr_data_i),
        .ra_a_i(paddr[1]),
        .rd_a_o(rd_a_data_o),
        .ra_b_i(paddr[2]),
        .rd_b_o(rd_b_data_o)
    );

    assign cwp_o = cwp;

endmodule

// File: rtl/rwf_window_file_chk.sv
module rwf_window_file_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NWIN   = 8,
    parameter int unsigned LREG_W = 5,
    localparam int unsigned PW    = $clog2(NWIN)
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              call_i,
    input logic              ret_i,
    input logic              save_ack_i,
    input logic              restore_ack_i,
    input logic [LREG_W-1:0] rd_a_addr_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic              ovf_trap_o,
    input logic              unf_trap_o,
    input logic [PW-1:0]     cwp_o,
    input logic [PW-1:0]     swp_o
);

    AST_CALL_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
        (call_i && !ret_i && !ovf_trap_o) |=> (cwp_o == PW'($past(cwp_o) + 1'b1))); // R3
    AST_RET_BACK: assert property (@(posedge clk_i) disable iff (rst_i)
        (ret_i && !call_i && !unf_trap_o) |=> (cwp_o == PW'($past(cwp_o) - 1'b1))); // R3
    AST_OVF_HOLDS_CWP: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_trap_o |=> $stable(cwp_o)); // R5
    AST_OVF_NEEDS_CALL: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_trap_o |-> (call_i && PW'(cwp_o + 2'd2) == swp_o)); // R5
    AST_UNF_HOLDS_CWP: assert property (@(posedge clk_i) disable iff (rst_i)
        unf_trap_o |=> $stable(cwp_o)); // R6
    AST_UNF_NEEDS_RET: assert property (@(posedge clk_i) disable iff (rst_i)
        unf_trap_o |-> (ret_i && cwp_o == swp_o)); // R6
    AST_SAVE_ADVANCES: assert property (@(posedge clk_i) disable iff (rst_i)
        (ovf_trap_o && save_ack_i) |=> (swp_o == PW'($past(swp_o) + 1'b1))); // R7
    AST_SWP_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!(ovf_trap_o && save_ack_i) && !(unf_trap_o && restore_ack_i)) |=> $stable(swp_o)); // R7
    AST_G0_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_a_addr_i == '0) |-> (rd_a_data_o == '0)); // R8
    AST_BOTH_NOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (call_i && ret_i) |=> ($stable(cwp_o) && $stable(swp_o))); // R11
    AST_BOTH_NO_TRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (call_i && ret_i) |-> !(ovf_trap_o || unf_trap_o)); // R11

endmodule

bind rwf_window_file rwf_window_file_chk #(
    .DATA_W(DATA_W), .NWIN(NWIN), .LREG_W(LREG_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .save_ack_i   (save_ack_i),
    .restore_ack_i(restore_ack_i),
    .rd_a_addr_i  (rd_a_addr_i),
    .rd_a_data_o  (rd_a_data_o),
    .ovf_trap_o   (ovf_trap_o),
    .unf_trap_o   (unf_trap_o),
    .cwp_o        (cwp_o),
    .swp_o        (swp_o)
);

// File: tb/rwf_window_file_test.sv
module rwf_window_file_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call = 1'b0, ret = 1'b0, sack = 1'b0, rack = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  wa = '0, ra = '0, rb = '0;
    logic [31:0] wd = '0;
    logic [31:0] rda, rdb;
    logic        ovf, unf;
    logic [2:0]  cwp, swp;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural model
    int m_cwp = 0;
    int m_swp = 0;
    logic [31:0] m_regs [int];

    always #10 clk = ~clk;

    rwf_window_file uut (
        .clk_i(clk), .rst_i(rst), .call_i(call), .ret_i(ret),
        .save_ack_i(sack), .restore_ack_i(rack),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
        .rd_a_addr_i(ra), .rd_a_data_o(rda),
        .rd_b_addr_i(rb), .rd_b_data_o(rdb),
        .ovf_trap_o(ovf), .unf_trap_o(unf), .cwp_o(cwp), .swp_o(swp)
    );

    // R1/R2/R4: key of a logical register seen from window w
    function automatic int key_of(logic [4:0] a, int w);
        int g = int'(a[4:3]);
        int i = int'(a[2:0]);
        if (g == 0) return i;
        if (g == 1) return 1000 + w * 100 + i;
        if (g == 2) return 1000 + w * 100 + 50 + i;
        return 1000 + ((w + 1) % 8) * 100 + i;
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        int k = key_of(a, m_cwp);
        if (a == 5'd0) return 32'd0;
        if (m_regs.exists(k)) return m_regs[k];
        return 32'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs set at negedge; compare comb outputs, then advance one edge
    task automatic cycle();
        logic eo, eu;
        #5;
        eo = call && !ret && (((m_cwp + 2) % 8) == m_swp);
        eu = ret && !call && (m_cwp == m_swp);
        check("R1/R2 read port A", rda, m_read(ra));
        check("R1/R2 read port B", rdb, m_read(rb));
        check("R5 overflow", 32'(ovf), 32'(eo));
        check("R6 underflow", 32'(unf), 32'(eu));
        check("R3 current pointer", 32'(cwp), 32'(m_cwp));
        check("R7 saved pointer", 32'(swp), 32'(m_swp));
        @(posedge clk);
        if (we && wa != 5'd0) m_regs[key_of(wa, m_cwp)] = wd; // R12 old pointer
        if (call && !ret && !eo) m_cwp = (m_cwp + 1) % 8;
        else if (ret && !call && !eu) m_cwp = (m_cwp + 7) % 8;
        if (eo && sack) m_swp = (m_swp + 1) % 8;
        else if (eu && rack) m_swp = (m_swp + 7) % 8;
        @(negedge clk);
    endtask

    task automatic idle();
        call = 0; ret = 0; sack = 0; rack = 0; we = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R9: reset state
        #5;
        check("R9 cwp after reset", 32'(cwp), 32'd0);
        check("R9 swp after reset", 32'(swp), 32'd0);
        for (int a = 0; a < 32; a++) begin
            ra = 5'(a); #1;
            check("R9 register zero after reset", rda, 32'd0);
        end
        @(negedge clk);

        // R8: write to global 0 ignored
        idle(); we = 1; wa = 5'd0; wd = 32'hDEAD_BEEF; ra = 5'd0; rb = 5'd0; cycle();
        idle(); #5; check("R8 global zero reads zero", rda, 32'd0); @(negedge clk);

        // R10: read during write returns old value
        idle(); we = 1; wa = 5'd16; wd = 32'h1111_2222; ra = 5'd16; #5;
        check("R10 old value during write", rda, 32'd0); @(negedge clk);
        m_regs[key_of(5'd16, m_cwp)] = 32'h1111_2222;
        idle(); ra = 5'd16; #5;
        check("R10 new value next cycle", rda, 32'h1111_2222); @(negedge clk);

        // R2: temporary 3 becomes callee parameter 3; R4 global 5 persists
        idle(); we = 1; wa = 5'd27; wd = 32'hA5A5_0003; cycle();
        idle(); we = 1; wa = 5'd5; wd = 32'h0000_0555; cycle();
        // R12: write local 1 together with the call
        idle(); call = 1; we = 1; wa = 5'd17; wd = 32'h7777_0001; cycle();
        idle(); ra = 5'd11; rb = 5'd5; #5;
        check("R2 callee parameter aliases caller temporary", rda, 32'hA5A5_0003);
        check("R4 global visible after call", rdb, 32'h0000_0555);
        check("R3 cwp after call", 32'(cwp), 32'd1);
        @(negedge clk);
        idle(); ra = 5'd17; #5;
        check("R2 callee local distinct", rda, 32'd0); @(negedge clk);
        idle(); ret = 1; cycle();
        idle(); ra = 5'd17; #5;
        check("R12 write went to caller window", rda, 32'h7777_0001);
        check("R3 cwp after return", 32'(cwp), 32'd0);
        @(negedge clk);

        // R11: both strobes
        idle(); call = 1; ret = 1; #5;
        check("R11 no trap on both", 32'(ovf | unf), 32'd0); @(negedge clk);
        idle(); #5; check("R11 cwp unchanged", 32'(cwp), 32'd0); @(negedge clk);

        // R6/R7: underflow at reset depth, ignored ack, then fill
        idle(); ret = 1; sack = 1; cycle();
        idle(); ret = 1; #5;
        check("R6 underflow raised", 32'(unf), 32'd1);
        check("R7 stray save ack ignored", 32'(swp), 32'd0); @(negedge clk);
        idle(); ret = 1; rack = 1; cycle();
        idle(); ret = 1; cycle();
        idle(); #5;
        check("R7 swp after restore", 32'(swp), 32'd7);
        check("R3 cwp wrapped to 7", 32'(cwp), 32'd7); @(negedge clk);

        // R5: calls until overflow
        for (int n = 0; n < 7; n++) begin idle(); call = 1; cycle(); end
        idle(); call = 1; #5;
        check("R5 overflow after six calls", 32'(ovf), 32'd1);
        check("R5 cwp held at 5", 32'(cwp), 32'd5); @(negedge clk);
        idle(); call = 1; sack = 1; cycle();
        idle(); call = 1; cycle();
        idle(); #5;
        check("R7 swp after save", 32'(swp), 32'd0);
        check("R3 cwp after overflow resolved", 32'(cwp), 32'd6); @(negedge clk);

        // random traffic with model compare each cycle
        for (int c = 0; c < 6000; c++) begin
            int r = int'($urandom_range(0, 99));
            idle();
            call = (r < 22);
            ret  = (r >= 20 && r < 44);
            we   = ($urandom_range(0, 1) == 1);
            wa   = 5'($urandom);
            wd   = $urandom;
            ra   = 5'($urandom);
            rb   = 5'($urandom);
            sack = ($urandom_range(0, 2) == 0);
            rack = ($urandom_range(0, 2) == 0);
            cycle();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule